// File: doc/BRIEF.md
# Frequency-Coded Line State Codec

This block carries the three arbitration line states (one, zero and a released "Z" state) over a pair without using DC levels. Each state is sent as a square wave whose toggle rate is a fixed fraction of the local clock. The amplitude is the same for every state. When the transmitter is not enabled, its output enable is dropped so that the driver floats.

The receive side passes the incoming line through a synchronizer and measures the number of clocks between successive transitions. It maps each interval to a state, using a tolerance window for the slowest state. A new state is reported only when two intervals in a row agree. Intervals that are too long for any state raise a one-cycle error pulse. A silent line is reported as idle. A wake output, which a clock gate around the arbitration logic would use, is high whenever the line shows activity or the transmitter is enabled.

Top module: `fsk_line_codec`

## Requirements
- R1: When `tx_en_i` is low at a clock edge, `line_oe_o` and `line_o` are both 0 after that edge (the driver is released).
- R2: While enabled, `line_o` holds each level for H clocks. Symbol codes on `tx_sym_i` are: 2'b01 = one (H=1), 2'b00 = zero (H=2), 2'b10 = Z (H=4), and 2'b11 is sent as Z.
- R3: The transmitter samples `tx_sym_i` only at a toggle (and on every disabled cycle). A symbol change in mid half-period takes effect from the next toggle. The first toggle comes H edges after the first edge that sees `tx_en_i` high; the line starts at 0.
- R4: `line_i` passes through two synchronizer flops. The clock count between two successive transitions is classified as follows: 1 = one (2'b01), 2 = zero (2'b00), 3 to 5 = Z (2'b10).
- R5: `rx_sym_o` changes, and `rx_valid_o` is set, only when two consecutive intervals give the same class. A single interval of a different class leaves `rx_sym_o` unchanged.
- R6: An interval of 6 to 16 clocks gives a one-cycle `rx_err_o` pulse, clears `rx_valid_o` and restarts the agreement.
- R7: After more than 16 clocks without a transition, `rx_idle_o` is 1 and `rx_valid_o` is 0. The first transition after idle only starts a new measurement and clears `rx_idle_o`.
- R8: `wake_o` is 1 exactly when the receiver is not idle or the transmitter output is enabled.
- R9: During reset, `line_oe_o`, `line_o`, `rx_valid_o`, `rx_err_o` and `wake_o` are 0, `rx_idle_o` is 1 and `rx_sym_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable |
| tx_sym_i | input | 2 | Symbol to send |
| line_o | output | 1 | Transmit line level |
| line_oe_o | output | 1 | Transmit driver enable (0 = high impedance) |
| line_i | input | 1 | Receive line, asynchronous |
| rx_sym_o | output | 2 | Last confirmed received symbol |
| rx_valid_o | output | 1 | `rx_sym_o` is confirmed |
| rx_err_o | output | 1 | One-cycle pulse on an out-of-range interval |
| rx_idle_o | output | 1 | Receive line silent |
| wake_o | output | 1 | Clock-enable request for the arbitration logic |

## Verification
The receiver is driven with steady trains at 1, 2 and 4 clocks per level, which separates the three base classes. Trains at 3 and 5 clocks probe the edges of the Z window. A lone odd interval inside a steady train shows that agreement is needed before the output changes. Intervals of 8 and 16 clocks must give errors and a gap of more than 16 must give idle, which separates error from idle at the limit. The transmitter is looped back onto the receiver for every symbol code, including a change in mid half-period and the unused code. This checks the toggle timing and the end-to-end decode together.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_Z    = 2'b10
  } sym_e;
endpackage

// File: rtl/fsk_tx_gen.sv
module fsk_tx_gen #(
  parameter int HALF_ONE  = 1,
  parameter int HALF_ZERO = 2,
  parameter int HALF_Z    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_en_i,
  input  logic [1:0] tx_sym_i,
  output logic       line_o,
  output logic       line_oe_o
);
  localparam int CW = $clog2(HALF_Z + 1);

  logic [CW-1:0] cnt_q, half_q, half_sel;
  logic          line_q, oe_q;

  always_comb begin
    unique case (tx_sym_i)
      fsk_pkg::SYM_ONE:  half_sel = CW'(HALF_ONE);
      fsk_pkg::SYM_ZERO: half_sel = CW'(HALF_ZERO);
      default:           half_sel = CW'(HALF_Z);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= CW'(HALF_Z);
      line_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= tx_en_i;
      if (!tx_en_i) begin
        cnt_q  <= '0;
        half_q <= half_sel;
        line_q <= 1'b0;
      end else if (cnt_q == half_q - CW'(1)) begin
        cnt_q  <= '0;
        half_q <= half_sel;
        line_q <= ~line_q;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign line_o    = line_q;
  assign line_oe_o = oe_q;

  // R1
  tx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (!line_oe_o && !line_o));

  // R2
  tx_fast_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && line_oe_o && half_q == CW'(HALF_ONE)) |=> (line_o != $past(line_o)));
endmodule

// File: rtl/fsk_rx_sync.sv
module fsk_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sq;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq[0] <= 1'b0;
        else         sq[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq[i] <= 1'b0;
        else         sq[i] <= sq[i-1];
      end
    end
  end

  assign q_o = sq[STAGES-1];
endmodule

// File: rtl/fsk_rx_classify.sv
module fsk_rx_classify #(
  parameter int HALF_ONE  = 1,
  parameter int HALF_ZERO = 2,
  parameter int HALF_Z    = 4,
  parameter int TOL       = 1,
  parameter int IDLE_LIM  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  output logic [1:0] rx_sym_o,
  output logic       rx_valid_o,
  output logic       rx_err_o,
  output logic       rx_idle_o
);
  import fsk_pkg::*;

  localparam int RW   = $clog2(IDLE_LIM + 2);
  localparam int SAT  = IDLE_LIM + 1;

  logic          last_q, edge_w;
  logic [RW-1:0] run_q;
  logic          prev_ok_q, valid_q, err_q;
  sym_e          prev_cls_q, sym_q, cls_w;
  logic          bad_w;

  assign edge_w = lvl_i ^ last_q;

  // nearest-class mapping; Z window checked first so it owns its overlap
  always_comb begin
    bad_w = 1'b0;
    cls_w = SYM_Z;
    if (run_q >= RW'(HALF_Z - TOL) && run_q <= RW'(HALF_Z + TOL)) cls_w = SYM_Z;
    else if (run_q <= RW'(HALF_ONE))                               cls_w = SYM_ONE;
    else if (run_q <= RW'(HALF_ZERO + TOL))                        cls_w = SYM_ZERO;
    else                                                           bad_w = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q     <= 1'b0;
      run_q      <= RW'(SAT);
      prev_ok_q  <= 1'b0;
      prev_cls_q <= SYM_ZERO;
      sym_q      <= SYM_ZERO;
      valid_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      last_q <= lvl_i;
      err_q  <= 1'b0;
      if (edge_w) begin
        run_q <= RW'(1);
        if (run_q > RW'(IDLE_LIM)) begin
          prev_ok_q <= 1'b0;
        end else if (bad_w) begin
          err_q     <= 1'b1;
          valid_q   <= 1'b0;
          prev_ok_q <= 1'b0;
        end else begin
          if (prev_ok_q && prev_cls_q == cls_w) begin
            sym_q   <= cls_w;
            valid_q <= 1'b1;
          end
          prev_cls_q <= cls_w;
          prev_ok_q  <= 1'b1;
        end
      end else begin
        if (run_q >= RW'(IDLE_LIM)) begin
          valid_q   <= 1'b0;
          prev_ok_q <= 1'b0;
        end
        if (run_q < RW'(SAT)) run_q <= run_q + RW'(1);
      end
    end
  end

  assign rx_sym_o   = sym_q;
  assign rx_valid_o = valid_q;
  assign rx_err_o   = err_q;
  assign rx_idle_o  = run_q > RW'(IDLE_LIM);

  // R6
  rx_err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |=> !rx_err_o);

  // R6
  rx_err_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |-> !rx_valid_o);

  // R7
  rx_idle_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_idle_o |-> !rx_valid_o);

  // R5
  rx_sym_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_sym_o) |-> rx_valid_o);
endmodule

// File: rtl/fsk_line_codec.sv
module fsk_line_codec #(
  parameter int HALF_ONE    = 1,
  parameter int HALF_ZERO   = 2,
  parameter int HALF_Z      = 4,
  parameter int TOL         = 1,
  parameter int IDLE_LIM    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_en_i,
  input  logic [1:0] tx_sym_i,
  output logic       line_o,
  output logic       line_oe_o,
  input  logic       line_i,
  output logic [1:0] rx_sym_o,
  output logic       rx_valid_o,
  output logic       rx_err_o,
  output logic       rx_idle_o,
  output logic       wake_o
);
  logic lvl_w;

  fsk_tx_gen #(
    .HALF_ONE (HALF_ONE),
    .HALF_ZERO(HALF_ZERO),
    .HALF_Z   (HALF_Z)
  ) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_en_i  (tx_en_i),
    .tx_sym_i (tx_sym_i),
    .line_o   (line_o),
    .line_oe_o(line_oe_o)
  );

  fsk_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (lvl_w)
  );

  fsk_rx_classify #(
    .HALF_ONE (HALF_ONE),
    .HALF_ZERO(HALF_ZERO),
    .HALF_Z   (HALF_Z),
    .TOL      (TOL),
    .IDLE_LIM (IDLE_LIM)
  ) u_cls (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl_w),
    .rx_sym_o  (rx_sym_o),
    .rx_valid_o(rx_valid_o),
    .rx_err_o  (rx_err_o),
    .rx_idle_o (rx_idle_o)
  );

  assign wake_o = ~rx_idle_o | line_oe_o;

  // R8
  wake_on_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> wake_o);

  // R8
  wake_on_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tx_en_i) |-> wake_o);
endmodule

// File: tb/tb_fsk_line_codec.sv
module tb_fsk_line_codec;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b0;
  logic [1:0] tx_sym_i = 2'b00;
  logic       line_o, line_oe_o, line_i;
  logic [1:0] rx_sym_o;
  logic       rx_valid_o, rx_err_o, rx_idle_o, wake_o;
  logic       loop = 1'b0;
  logic       drv = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  assign line_i = loop ? line_o : drv;

  fsk_line_codec dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .tx_sym_i(tx_sym_i),
    .line_o(line_o), .line_oe_o(line_oe_o), .line_i(line_i),
    .rx_sym_o(rx_sym_o), .rx_valid_o(rx_valid_o), .rx_err_o(rx_err_o),
    .rx_idle_o(rx_idle_o), .wake_o(wake_o)
  );

  // behavioural reference model
  int m_cnt, m_half, m_line, m_oe;
  int h0, h1, h2;
  int m_gap, m_sym, m_valid, m_err, m_prev_ok, m_prev_c;

  function automatic int half_of(input logic [1:0] s);
    if (s == 2'b01) return 1;
    if (s == 2'b00) return 2;
    return 4;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cnt = 0; m_half = 4; m_line = 0; m_oe = 0;
      h0 = 0; h1 = 0; h2 = 0;
      m_gap = 17; m_sym = 0; m_valid = 0; m_err = 0; m_prev_ok = 0; m_prev_c = 0;
    end else begin
      bit ed;
      m_oe = tx_en_i;
      if (!tx_en_i) begin
        m_line = 0; m_cnt = 0; m_half = half_of(tx_sym_i);
      end else if (m_cnt == m_half - 1) begin
        m_line ^= 1; m_cnt = 0; m_half = half_of(tx_sym_i);
      end else m_cnt++;

      ed = (h1 != h2);
      h2 = h1; h1 = h0; h0 = int'(line_i);
      m_err = 0;
      if (ed) begin
        if (m_gap > 16) m_prev_ok = 0;
        else if (m_gap >= 6) begin
          m_err = 1; m_valid = 0; m_prev_ok = 0;
        end else begin
          int c;
          c = (m_gap == 1) ? 1 : (m_gap == 2) ? 0 : 2;
          if (m_prev_ok && m_prev_c == c) begin m_sym = c; m_valid = 1; end
          m_prev_c = c; m_prev_ok = 1;
        end
        m_gap = 1;
      end else begin
        if (m_gap >= 16) begin m_valid = 0; m_prev_ok = 0; end
        if (m_gap < 17) m_gap++;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(line_oe_o, m_oe, "R1 line_oe_o");
      chk(line_o, m_line, "R2/R3 line_o");
      chk(rx_sym_o, m_sym, "R4 rx_sym_o");
      chk(rx_valid_o, m_valid, "R5 rx_valid_o");
      chk(rx_err_o, m_err, "R6 rx_err_o");
      chk(rx_idle_o, int'(m_gap > 16), "R7 rx_idle_o");
      chk(wake_o, int'(m_gap <= 16 || m_oe != 0), "R8 wake_o");
    end
  end

  task automatic hold(input int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic tog(input int half, input int n);
    for (int i = 0; i < n; i++) begin drv = ~drv; hold(half); end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(line_oe_o, 0, "R9 oe"); chk(line_o, 0, "R9 line");
    chk(rx_valid_o, 0, "R9 valid"); chk(rx_err_o, 0, "R9 err");
    chk(rx_idle_o, 1, "R9 idle"); chk(wake_o, 0, "R9 wake");
    chk(rx_sym_o, 0, "R9 sym");
    @(posedge clk_i); #1 rst_ni = 1'b1;
    hold(4);

    // receive patterns
    tog(1, 8);
    @(negedge clk_i); chk(rx_sym_o, 1, "R4 one"); chk(rx_valid_o, 1, "R5 one valid");
    tog(2, 8);
    @(negedge clk_i); chk(rx_sym_o, 0, "R4 zero");
    tog(4, 6);
    @(negedge clk_i); chk(rx_sym_o, 2, "R4 Z");
    tog(3, 4); tog(5, 4);
    @(negedge clk_i); chk(rx_sym_o, 2, "R4 Z window edges");
    tog(2, 4); tog(1, 1); tog(2, 4);
    @(negedge clk_i); chk(rx_sym_o, 0, "R5 single odd interval");
    tog(8, 2); tog(16, 1); tog(2, 3);
    hold(20);
    @(negedge clk_i);
    chk(rx_idle_o, 1, "R7 idle"); chk(wake_o, 0, "R8 sleep"); chk(rx_valid_o, 0, "R7 valid");
    tog(17, 1); tog(4, 4);

    // transmit, looped back
    drv = 1'b0; hold(20);
    loop = 1'b1;
    tx_sym_i = 2'b01; tx_en_i = 1'b1; hold(20);
    tx_sym_i = 2'b00; hold(21);
    @(negedge clk_i); chk(rx_sym_o, 0, "R5 loop zero"); chk(wake_o, 1, "R8 tx wake");
    @(posedge clk_i); #1 tx_sym_i = 2'b10; hold(30);
    tx_sym_i = 2'b11; hold(21);
    @(negedge clk_i); chk(rx_sym_o, 2, "R2 unused code as Z");
    tx_sym_i = 2'b01; hold(3);
    tx_en_i = 1'b0; hold(5);
    @(negedge clk_i); chk(line_oe_o, 0, "R1 released"); chk(line_o, 0, "R1 low");
    hold(25);
    @(negedge clk_i); chk(wake_o, 0, "R8 asleep after tx");
    finish_run();
  end
endmodule